// File: doc/BRIEF.md
# Double-Buffered Interleaver Store

This block is the storage half of a block interleaver. It holds two equal RAM banks. While coded symbols of the current block are written into one bank at the permuted addresses supplied by an external address generator, the previous block is read out of the other bank at sequential addresses. When the last symbol of a block is accepted, the banks exchange jobs. The next block then fills the bank that has just been drained, and the block that has just been completed is read out.

A single flag steers the whole datapath. The flag and its complement route either the write address or the read address to each bank and gate each bank's write strobe. The same flag also selects which bank drives the output register. Reads are paced by writes: every accepted input symbol also reads one symbol out. The output therefore streams with no pause at block edges. Output valid stays low until a first complete block has been stored, so bank contents left over from before reset never reach the output.

Top module: `ilv_pingpong`

## Requirements
- R1: While reset is asserted, `out_valid` is 0 and `out_data` is all zeros.
- R2: Until an accepted symbol has arrived together with `blk_done`, `out_valid` stays 0 whatever the inputs do.
- R3: Once a first block is complete, `out_valid` is 1 in the cycle after each cycle with `in_valid` = 1, and 0 in the cycle after each cycle with `in_valid` = 0.
- R4: When `out_valid` is 1, `out_data` equals the symbol that the most recently completed block wrote at the `rd_addr` presented one cycle earlier.
- R5: A cycle with `in_valid` = 1 and `blk_done` = 1 exchanges the banks at that clock edge. The very next accepted symbol starts the new block, and the read made in that same cycle returns data from the block that has just been completed, so no idle cycle appears between blocks.
- R6: A cycle with `in_valid` = 0 writes nothing, whatever `wr_addr` and `in_data` hold.
- R7: `blk_done` has no effect in a cycle with `in_valid` = 0; the banks are not exchanged.
- R8: While `out_valid` is 0, `out_data` keeps its previous value.
- R9: Any permutation of write addresses and any order of read addresses over the block length give the behaviour of R4. This includes reading in reverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input symbol present this cycle |
| in_data | input | DW | Coded input symbol |
| wr_addr | input | AW | Permuted write address for the input symbol |
| rd_addr | input | AW | Read address into the completed block |
| blk_done | input | 1 | Marks the current symbol as the last of its block |
| out_valid | output | 1 | Output symbol present this cycle |
| out_data | output | DW | Interleaved output symbol |

## Verification
The hardest situation to reach is the boundary cycle of a swap, where one accepted symbol both closes a block and reads from the bank that is about to become the write bank. It is followed at once by a read of the freshly completed bank. The stimulus runs several blocks back to back, each with a different stride permutation, and marks the last symbol of every block. That boundary therefore occurs again and again with no idle cycles around it. A further block pauses every few symbols. During each pause it drives a junk write address, junk data and a spurious block-end mark. A write or swap that should have been ignored then shows up as a mismatch once that block is read back.

// File: rtl/ilv_pingpong.sv
module ilv_pingpong #(
  parameter int DW    = 8,
  parameter int DEPTH = 48,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] rd_addr,
  input  logic          blk_done,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);

  logic [DW-1:0] bank_a [DEPTH];
  logic [DW-1:0] bank_b [DEPTH];

  logic          sel;
  logic          primed;
  logic [AW-1:0] addr_a, addr_b;
  logic          we_a, we_b;
  logic          rd_en;
  logic [DW-1:0] rd_word;

  // sel = 0: bank_a is read, bank_b is written
  assign addr_a  = sel ? wr_addr : rd_addr;
  assign addr_b  = sel ? rd_addr : wr_addr;
  assign we_a    = in_valid &  sel;
  assign we_b    = in_valid & ~sel;
  assign rd_en   = in_valid & primed;
  assign rd_word = sel ? bank_b[addr_b] : bank_a[addr_a];

  always_ff @(posedge clk) begin
    if (we_a) bank_a[addr_a] <= in_data;
    if (we_b) bank_b[addr_b] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel       <= 1'b0;
      primed    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= rd_en;
      if (rd_en) out_data <= rd_word;
      if (in_valid && blk_done) begin
        sel    <= ~sel;
        primed <= 1'b1;
      end
    end
  end

endmodule

module ilv_pingpong_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          blk_done,
  input logic          sel,
  input logic          primed,
  input logic          out_valid,
  input logic [DW-1:0] out_data
);

  always @(posedge clk)
    if (!rst_n) assert_reset_quiet_R1: assert (!out_valid && out_data == '0);

  assert_no_early_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |=> !out_valid);

  assert_valid_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && primed) |=> out_valid);

  assert_idle_no_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_swap_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && blk_done) |=> (sel != $past(sel)));

  assert_done_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid) |=> $stable(sel));

  assert_hold_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

endmodule

bind ilv_pingpong ilv_pingpong_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .blk_done(blk_done),
  .sel(sel), .primed(primed), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sim_ilv_pingpong.sv
`timescale 1ns/1ps
module sim_ilv_pingpong;
  localparam int DW = 8;
  localparam int DEPTH = 48;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, blk_done = 0;
  logic [DW-1:0] in_data = '0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic out_valid;
  logic [DW-1:0] out_data;

  int total = 0, bad = 0;
  bit done_run = 0;

  logic [DW-1:0] wb [DEPTH];
  logic [DW-1:0] rb [DEPTH];
  bit            m_primed = 0;
  logic [DW-1:0] m_out = '0;

  always #4 clk = ~clk;

  ilv_pingpong #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .blk_done(blk_done),
    .out_valid(out_valid), .out_data(out_data));

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit v, input logic [DW-1:0] d, input int wa, input int ra,
                     input bit dn, input string dtag);
    bit            e_v;
    logic [DW-1:0] e_d;
    @(negedge clk);
    in_valid = v; in_data = d; wr_addr = AW'(wa); rd_addr = AW'(ra); blk_done = dn;
    e_v = v && m_primed;
    e_d = e_v ? rb[ra] : m_out;
    @(posedge clk); #2;
    check(m_primed ? "R3" : "R2", DW'(out_valid), DW'(e_v));
    check(e_v ? dtag : "R8", out_data, e_d);
    m_out = e_d;
    if (v) wb[wa] = d;
    if (v && dn) begin
      foreach (rb[k]) rb[k] = wb[k];
      m_primed = 1;
    end
  endtask

  task automatic run_block(input int stride, input bit rev, input bit gaps);
    for (int i = 0; i < DEPTH; i++) begin
      if (gaps && (i % 5 == 4))
        cyc(0, DW'($urandom), int'($urandom % DEPTH), i, 1, "R7");
      cyc(1, DW'($urandom), (i * stride) % DEPTH, rev ? DEPTH-1-i : i,
          i == DEPTH-1, (i == 0) ? "R5" : (rev ? "R9" : "R4"));
    end
  endtask

  initial begin
    foreach (rb[k]) begin rb[k] = '0; wb[k] = '0; end
    repeat (3) @(posedge clk);
    #2;
    check("R1", DW'(out_valid), '0);
    check("R1", out_data, '0);
    @(negedge clk); rst_n = 1;
    // first block, nothing valid yet (R2)
    run_block(7, 0, 0);
    // back-to-back blocks with different permutations (R4, R5, R9)
    run_block(11, 0, 0);
    run_block(5, 1, 0);
    run_block(1, 0, 0);
    // idle cycles with junk writes and stray block-end marks (R6, R7, R8)
    for (int j = 0; j < 6; j++)
      cyc(0, DW'($urandom), j * 3, j, 1, "R6");
    // block interrupted by pauses carrying junk (R6, R7)
    run_block(13, 0, 1);
    // read back the interrupted block (R6)
    for (int i = 0; i < DEPTH; i++)
      cyc(1, DW'($urandom), (i * 7) % DEPTH, i, i == DEPTH-1, "R6");
    run_block(1, 1, 0);
    for (int j = 0; j < 3; j++) cyc(0, '0, 0, 0, 0, "R8");
    done_run = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_run) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule